// File: doc/BRIEF.md
# Double-Buffered LED Control Register Bank

This block holds the control state of an 18-channel LED current driver. A byte-wide write port (strobe, 8-bit address, 8-bit data) loads a run/shutdown control bit, one 8-bit duty value per channel, and one enable bit per channel packed six to a byte. The duty and enable values are double-buffered. A write lands in a staging copy. The active copy, which the PWM generator reads, changes only when a command write copies the whole staging set across in one cycle. This lets software rewrite any number of channels and then apply them all in the same clock.

The run bit is not buffered and takes effect on the edge that writes it. A second command address returns every register, staged and active, to its default. Addresses beyond the command addresses are ignored. The bus protocol that produces the write strobes is outside this block, and so is the PWM counter that consumes the outputs.

Top module: `led_regbank`

## Requirements
- R1: While `rst_ni` is low and after it rises, `duty_o`, `led_en_o` and `run_o` are all zero.
- R2: A write to address 0x00 sets `run_o` to `wr_data_i[0]` on the next clock edge (1 = run, 0 = shutdown), and the other data bits are discarded. No other write changes `run_o`, except the reset command (R7).
- R3: A write to address 0x01..0x12 stores the byte as the staged duty of channel 1..18 and does not change any output. Active channel k appears on `duty_o[8k-1:8k-8]`.
- R4: A write to 0x13, 0x14 or 0x15 stores data bits 5:0 as the staged enables of channels 1–6, 7–12 or 13–18, with bit j going to the lowest channel of the group plus j. Bits 7:6 are discarded, and no output changes. Active channel k appears on `led_en_o[k-1]`.
- R5: A write of any byte to 0x16 copies every staged duty and enable value to `duty_o` and `led_en_o` on the next edge, all in the same cycle.
- R6: The staging copy keeps its contents after an update, so a repeated update with no staging writes in between leaves the outputs unchanged.
- R7: A write of any byte to 0x17 clears the staged values, the active values and `run_o` on the next edge. A later update then yields all-zero outputs.
- R8: Writes to addresses 0x18..0xFF change neither the outputs nor the staged values.
- R9: With `wr_en_i` low, no register changes, whatever `wr_addr_i` and `wr_data_i` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | 8 | Register address |
| wr_data_i | input | 8 | Write data |
| duty_o | output | 144 | Active duty values, 8 bits per channel, channel 1 in the low byte |
| led_en_o | output | 18 | Active channel enables, channel 1 at bit 0 |
| run_o | output | 1 | 1 = run, 0 = shutdown |

## Verification
Every result is due one clock edge after its write. The run bit, the update copy and the reset clear each pass through exactly one register stage. Staging writes never reach the ports, so they are observed through a later update write, which is also due one edge after it is issued. The bench drives each write on a falling edge and releases it on the next falling edge. It compares all outputs with its model at that second falling edge, half a period after the edge that captured the write, so every comparison falls where the result is due and before the next stimulus.

// File: rtl/led_regbank_pkg.sv
package led_regbank_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 8;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
  localparam addr_t RUN_ADDR = '0;
endpackage

// File: rtl/led_regbank_decode.sv
module led_regbank_decode
  import led_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH  = 18,
  parameter int unsigned NUM_GRP = 3
) (
  input  logic               wr_en_i,
  input  addr_t              addr_i,
  output logic               sel_run_o,
  output logic [NUM_CH-1:0]  sel_duty_o,
  output logic [NUM_GRP-1:0] sel_grp_o,
  output logic               sel_upd_o,
  output logic               sel_rst_o
);
  localparam int unsigned EN_BASE = NUM_CH + 1;
  localparam addr_t UPD_ADDR = addr_t'(EN_BASE + NUM_GRP);
  localparam addr_t RST_ADDR = addr_t'(EN_BASE + NUM_GRP + 1);

  assign sel_run_o = wr_en_i && (addr_i == RUN_ADDR);
  assign sel_upd_o = wr_en_i && (addr_i == UPD_ADDR);
  assign sel_rst_o = wr_en_i && (addr_i == RST_ADDR);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_duty_sel
    localparam addr_t A = addr_t'(k + 1);
    assign sel_duty_o[k] = wr_en_i && (addr_i == A);
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp_sel
    localparam addr_t A = addr_t'(EN_BASE + g);
    assign sel_grp_o[g] = wr_en_i && (addr_i == A);
  end
endmodule

// File: rtl/led_regbank_stage.sv
module led_regbank_stage
  import led_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH   = 18,
  parameter int unsigned GRP_SIZE = 6,
  parameter int unsigned NUM_GRP  = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic [NUM_CH-1:0]        sel_duty_i,
  input  logic [NUM_GRP-1:0]       sel_grp_i,
  input  byte_t                    data_i,
  output logic [NUM_CH*DATA_W-1:0] duty_o,
  output logic [NUM_CH-1:0]        en_o
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam int unsigned G = k / GRP_SIZE;
    localparam int unsigned J = k % GRP_SIZE;
    byte_t duty_q;
    logic  en_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            duty_q <= '0;
      else if (clr_i)         duty_q <= '0;
      else if (sel_duty_i[k]) duty_q <= data_i;
    end

    // only the low GRP_SIZE data bits carry enables; the rest are dropped
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          en_q <= 1'b0;
      else if (clr_i)       en_q <= 1'b0;
      else if (sel_grp_i[G]) en_q <= data_i[J];
    end

    assign duty_o[k*DATA_W +: DATA_W] = duty_q;
    assign en_o[k] = en_q;
  end
endmodule

// File: rtl/led_regbank_active.sv
module led_regbank_active
  import led_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     load_i,
  input  logic [NUM_CH*DATA_W-1:0] stage_duty_i,
  input  logic [NUM_CH-1:0]        stage_en_i,
  input  logic                     sel_run_i,
  input  logic                     run_bit_i,
  output logic [NUM_CH*DATA_W-1:0] duty_o,
  output logic [NUM_CH-1:0]        en_o,
  output logic                     run_o
);
  // whole-set parallel copy: the PWM never sees a mix of old and new
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_o <= '0;
      en_o   <= '0;
    end else if (clr_i) begin
      duty_o <= '0;
      en_o   <= '0;
    end else if (load_i) begin
      duty_o <= stage_duty_i;
      en_o   <= stage_en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_o <= 1'b0;
    else if (clr_i)     run_o <= 1'b0;
    else if (sel_run_i) run_o <= run_bit_i;
  end
endmodule

// File: rtl/led_regbank.sv
module led_regbank
  import led_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH   = 18,
  parameter int unsigned GRP_SIZE = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  output logic [NUM_CH*DATA_W-1:0] duty_o,
  output logic [NUM_CH-1:0]        led_en_o,
  output logic                     run_o
);
  localparam int unsigned NUM_GRP = (NUM_CH + GRP_SIZE - 1) / GRP_SIZE;

  logic                     sel_run, sel_upd, sel_rst;
  logic [NUM_CH-1:0]        sel_duty;
  logic [NUM_GRP-1:0]       sel_grp;
  logic [NUM_CH*DATA_W-1:0] stage_duty_q;
  logic [NUM_CH-1:0]        stage_en_q;

  led_regbank_decode #(.NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP)) dec_i (
    .wr_en_i   (wr_en_i),
    .addr_i    (wr_addr_i),
    .sel_run_o (sel_run),
    .sel_duty_o(sel_duty),
    .sel_grp_o (sel_grp),
    .sel_upd_o (sel_upd),
    .sel_rst_o (sel_rst)
  );

  led_regbank_stage #(.NUM_CH(NUM_CH), .GRP_SIZE(GRP_SIZE), .NUM_GRP(NUM_GRP)) stage_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (sel_rst),
    .sel_duty_i(sel_duty),
    .sel_grp_i (sel_grp),
    .data_i    (wr_data_i),
    .duty_o    (stage_duty_q),
    .en_o      (stage_en_q)
  );

  led_regbank_active #(.NUM_CH(NUM_CH)) active_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (sel_rst),
    .load_i      (sel_upd),
    .stage_duty_i(stage_duty_q),
    .stage_en_i  (stage_en_q),
    .sel_run_i   (sel_run),
    .run_bit_i   (wr_data_i[0]),
    .duty_o      (duty_o),
    .en_o        (led_en_o),
    .run_o       (run_o)
  );
endmodule

// File: rtl/led_regbank_chk.sv
module led_regbank_chk
  import led_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH   = 18,
  parameter int unsigned GRP_SIZE = 6
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_en_i,
  input logic [ADDR_W-1:0]        wr_addr_i,
  input logic [DATA_W-1:0]        wr_data_i,
  input logic [NUM_CH*DATA_W-1:0] duty_o,
  input logic [NUM_CH-1:0]        led_en_o,
  input logic                     run_o,
  input logic [NUM_CH*DATA_W-1:0] stage_duty_i,
  input logic [NUM_CH-1:0]        stage_en_i
);
  localparam int unsigned NUM_GRP = (NUM_CH + GRP_SIZE - 1) / GRP_SIZE;
  localparam addr_t UPD = addr_t'(NUM_CH + 1 + NUM_GRP);
  localparam addr_t RST = addr_t'(NUM_CH + 2 + NUM_GRP);

  logic is_upd, is_rst, is_run, is_far;
  assign is_upd = wr_en_i && (wr_addr_i == UPD);
  assign is_rst = wr_en_i && (wr_addr_i == RST);
  assign is_run = wr_en_i && (wr_addr_i == RUN_ADDR);
  assign is_far = wr_en_i && (wr_addr_i > RST);

  p_run_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_run |=> run_o == $past(wr_data_i[0]));

  p_run_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(is_run || is_rst) |=> $stable(run_o));

  p_active_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(is_upd || is_rst) |=> $stable(duty_o) && $stable(led_en_o));

  p_update_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_upd |=> duty_o == $past(stage_duty_i) && led_en_o == $past(stage_en_i));

  p_clear_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rst |=> duty_o == '0 && led_en_o == '0 && !run_o && stage_duty_i == '0 && stage_en_i == '0);

  p_far_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_far |=> $stable(stage_duty_i) && $stable(stage_en_i));
endmodule

bind led_regbank led_regbank_chk #(.NUM_CH(NUM_CH), .GRP_SIZE(GRP_SIZE)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .duty_o      (duty_o),
  .led_en_o    (led_en_o),
  .run_o       (run_o),
  .stage_duty_i(stage_duty_q),
  .stage_en_i  (stage_en_q)
);

// File: tb/led_regbank_tb_top.sv
module led_regbank_tb_top;
  localparam int NCH = 18;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [7:0]      wr_addr = '0;
  logic [7:0]      wr_data = '0;
  logic [NCH*8-1:0] duty;
  logic [NCH-1:0]  led_en;
  logic            run;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0]     m_sduty [NCH];
  logic [7:0]     m_aduty [NCH];
  logic [NCH-1:0] m_sen, m_aen;
  logic           m_run;

  always #5 clk = ~clk;

  led_regbank dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .duty_o   (duty),
    .led_en_o (led_en),
    .run_o    (run)
  );

  task automatic model_clear();
    for (int k = 0; k < NCH; k++) begin
      m_sduty[k] = '0;
      m_aduty[k] = '0;
    end
    m_sen = '0;
    m_aen = '0;
    m_run = 1'b0;
  endtask

  // model written from the requirements
  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h00) m_run = d[0];
    else if (a <= 8'h12) m_sduty[a-1] = d;
    else if (a <= 8'h15) begin
      for (int j = 0; j < 6; j++) m_sen[(a-8'h13)*6 + j] = d[j];
    end else if (a == 8'h16) begin
      for (int k = 0; k < NCH; k++) m_aduty[k] = m_sduty[k];
      m_aen = m_sen;
    end else if (a == 8'h17) model_clear();
  endtask

  task automatic check(input string tag);
    logic [NCH*8-1:0] exp_duty;
    for (int k = 0; k < NCH; k++) exp_duty[k*8 +: 8] = m_aduty[k];
    n_chk++;
    if (duty !== exp_duty || led_en !== m_aen || run !== m_run) begin
      n_fail++;
      $display("FAIL %s: duty=%h en=%h run=%b expected duty=%h en=%h run=%b",
               tag, duty, led_en, run, exp_duty, m_aen, m_run);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    check(tag);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset");

    // R2 run bit, upper bits discarded
    wr(8'h00, 8'hFF, "R2 run set");
    wr(8'h00, 8'hFE, "R2 run clear with upper bits");
    wr(8'h00, 8'h01, "R2 run set again");

    // R3 staged duty writes stay hidden
    for (int k = 0; k < NCH; k++) wr(8'(k + 1), 8'((k * 29 + 7) & 255), "R3 staged duty");
    // R4 staged enable writes, reserved bits dropped
    wr(8'h13, 8'hFF, "R4 group 1");
    wr(8'h14, 8'hC5, "R4 group 2");
    wr(8'h15, 8'h6A, "R4 group 3");

    wr(8'h16, 8'h00, "R5 update");
    wr(8'h16, 8'h5A, "R6 repeat update");

    // R8 every address beyond the command range
    for (int a = 8'h18; a <= 8'hFF; a++) wr(8'(a), 8'(a ^ 8'hA5), "R8 far address");
    wr(8'h16, 8'h00, "R8 staging untouched");

    // R9 strobe low with a command address present
    @(negedge clk);
    wr_addr = 8'h17; wr_data = 8'hFF;
    repeat (4) @(negedge clk);
    check("R9 strobe low reset addr");
    wr_addr = 8'h16;
    repeat (2) @(negedge clk);
    check("R9 strobe low update addr");

    // partial restage then update
    wr(8'h05, 8'h11, "R3 restage ch5");
    wr(8'h12, 8'hEE, "R3 restage ch18");
    wr(8'h14, 8'h3A, "R4 restage group 2");
    wr(8'h16, 8'hFF, "R5 partial update");

    // R7 reset command
    wr(8'h17, 8'h00, "R7 reset command");
    wr(8'h16, 8'h00, "R7 update after reset");

    // R3/R5 exhaustive duty values on channel 1
    for (int v = 0; v < 256; v++) begin
      wr(8'h01, 8'(v), "R3 duty sweep stage");
      wr(8'h16, 8'h00, "R5 duty sweep update");
    end
    // R4 exhaustive enable byte on group 3
    for (int v = 0; v < 256; v++) begin
      wr(8'h15, 8'(v), "R4 enable sweep stage");
      wr(8'h16, 8'h00, "R5 enable sweep update");
    end

    wr(8'h00, 8'h01, "R2 run before reset");
    wr(8'h17, 8'h33, "R7 reset clears run");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule